// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block is a fully associative translation buffer for 32-bit virtual addresses. Each of its entries describes two neighbouring pages that share one tag: an even page and an odd page. Each half has its own frame number, valid bit and dirty bit. A page-size mask, held per entry, sets how large both pages are, from 4 KB up to 16 MB. An entry is either tied to one 8-bit address-space identifier or marked global.

Software-style loading goes through a write port that replaces a whole entry at a chosen index. The lookup port takes a virtual address, the current address-space identifier and a read/write flag. Every cycle the block compares the address against all entries in parallel. One cycle later it presents a registered result: a physical address, a write-permission flag and a two-bit result code. That code tells the surrounding pipeline whether the access can proceed, or which kind of refill or protection fault to raise.

Top module: `ptb_top`

## Requirements
- R1: After reset the result code is no-match (01), the physical address is 0 and write-permission is 0. Every entry is cleared to tag 0, identifier 0, mask 0, not global, with both halves invalid and clean.
- R2: An entry hits when either its global bit is set or its stored identifier equals `lk_asid`, and its tag equals the lookup address once the effective-mask bits are cleared from both. The tag is `wr_vpn2`, which stands for address bits 31..13.
- R3: The effective mask is the 13 low ones (two 4 KB pages) with the 12-bit page-mask field placed at bits 24..13. The field must hold contiguous low ones: 0x000 gives 4 KB pages, 0x003 gives 16 KB pages and 0xFFF gives 16 MB pages.
- R4: The odd half is selected when the lookup address bit just above the single-page offset is 1. That is bit 12 for 4 KB pages, bit 14 for 16 KB pages and bit 24 for 16 MB pages.
- R5: On a hit whose selected half is invalid, the code is invalid (10) for both reads and writes. The physical address is 0 and write-permission is 0.
- R6: On a write that hits a valid half whose dirty bit is clear, the code is modified (11). No translation is given: the address is 0 and write-permission is 0.
- R7: On a successful hit the code is match (00). The physical address is the selected frame number shifted left by 12, ORed with the lookup address bits below the selected page size. Write-permission equals that half's dirty bit, for reads as well as writes.
- R8: When no entry hits, the code is no-match (01), the address is 0 and write-permission is 0.
- R9: When several entries hit, the lowest index supplies the result.
- R10: The result appears one clock after the lookup inputs are applied. A write takes effect at the clock edge, so a lookup in the same cycle still sees the old contents of that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load an entry this cycle |
| wr_idx | input | 4 | Index of the entry to load |
| wr_vpn2 | input | 19 | Tag: virtual address bits 31..13 |
| wr_asid | input | 8 | Address-space identifier of the entry |
| wr_global | input | 1 | Entry matches any identifier |
| wr_mask | input | 12 | Page-size mask field |
| wr_pfn0 | input | 20 | Frame number of the even half |
| wr_v0 | input | 1 | Even half valid |
| wr_d0 | input | 1 | Even half dirty (writable) |
| wr_pfn1 | input | 20 | Frame number of the odd half |
| wr_v1 | input | 1 | Odd half valid |
| wr_d1 | input | 1 | Odd half dirty (writable) |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_write | input | 1 | 1 for a store access, 0 for a load |
| res_code | output | 2 | 00 match, 01 no-match, 10 invalid, 11 modified |
| res_pa | output | 32 | Translated physical address |
| res_wr_ok | output | 1 | Selected half may be written |

## Verification
The checks assume that software loads only contiguous-low-ones mask values. They also assume that frame numbers have their low bits clear up to the page size, so that the frame and the offset never overlap in the ORed address. Every entry the stimulus loads follows both rules, including the 16 KB and 16 MB cases. The reset-cleared entries also follow them, since they have mask 0. Lookups and writes are driven half a cycle away from the sampling edge, and the write port is given one index at a time, so the properties on the stored contents see a single well-defined update per edge.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int MASK_W     = 12;
    localparam int ASID_W     = 8;
    localparam int PFN_W      = VA_W - PAGE_SHIFT;
    localparam int VPN2_W     = VA_W - PAGE_SHIFT - 1;

    typedef enum logic [1:0] {
        RES_MATCH    = 2'b00,
        RES_NOMATCH  = 2'b01,
        RES_INVALID  = 2'b10,
        RES_MODIFIED = 2'b11
    } res_code_e;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [MASK_W-1:0] mask;
        logic [PFN_W-1:0]  pfn0;
        logic              v0;
        logic              d0;
        logic [PFN_W-1:0]  pfn1;
        logic              v1;
        logic              d1;
    } ptb_entry_t;

    typedef struct packed {
        res_code_e       code;
        logic [VA_W-1:0] pa;
        logic            wr_ok;
    } ptb_result_t;
endpackage

// File: rtl/ptb_store.sv
module ptb_store
    import ptb_pkg::*;
#(
    parameter int NUM_ENT = 16,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ptb_entry_t       wr_ent,
    output ptb_entry_t       ent_q [NUM_ENT]
);
    ptb_entry_t ent_d [NUM_ENT];

    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (wr_en) begin
            ent_d[wr_idx] = wr_ent;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_ENT; i++) begin
            if (!rst_n) ent_q[i] <= '0;
            else        ent_q[i] <= ent_d[i];
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ent_q[$past(wr_idx)] == $past(wr_ent)); // R10
endmodule

// File: rtl/ptb_match.sv
module ptb_match
    import ptb_pkg::*;
#(
    parameter int NUM_ENT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ptb_entry_t        ent [NUM_ENT],
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              hit_any,
    output logic              half_v,
    output logic              half_d,
    output logic [PFN_W-1:0]  half_pfn,
    output logic [VA_W-1:0]   half_offs
);
    localparam int LOW_W = PAGE_SHIFT + 1;

    logic [NUM_ENT-1:0] hit;
    logic [NUM_ENT-1:0] odd;
    logic [NUM_ENT-1:0] sel;
    logic [VA_W-1:0]    offs [NUM_ENT];

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        logic [VA_W-1:0] eff;
        logic [VA_W-1:0] ent_va;
        always_comb begin
            eff = '0;
            eff[LOW_W-1:0] = '1;
            eff[LOW_W+MASK_W-1:LOW_W] = ent[g].mask;
            ent_va = '0;
            ent_va[VA_W-1:LOW_W] = ent[g].vpn2;
        end
        assign hit[g]  = (ent[g].glob || (ent[g].asid == lk_asid)) &&
                         ((lk_va & ~eff) == (ent_va & ~eff));
        assign odd[g]  = |(lk_va & eff & ~(eff >> 1));
        assign offs[g] = lk_va & (eff >> 1);
    end

    always_comb begin
        logic found;
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (hit[i] && !found) begin
                sel[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    always_comb begin
        hit_any   = |hit;
        half_v    = 1'b0;
        half_d    = 1'b0;
        half_pfn  = '0;
        half_offs = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (sel[i]) begin
                half_v    = odd[i] ? ent[i].v1   : ent[i].v0;
                half_d    = odd[i] ? ent[i].d1   : ent[i].d0;
                half_pfn  = odd[i] ? ent[i].pfn1 : ent[i].pfn0;
                half_offs = offs[i];
            end
        end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R9
    AST_SEL_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |-> ((sel & hit) == sel) && (sel != '0)); // R9
endmodule

// File: rtl/ptb_top.sv
module ptb_top
    import ptb_pkg::*;
#(
    parameter int NUM_ENT = 16,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN2_W-1:0] wr_vpn2,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic [MASK_W-1:0] wr_mask,
    input  logic [PFN_W-1:0]  wr_pfn0,
    input  logic              wr_v0,
    input  logic              wr_d0,
    input  logic [PFN_W-1:0]  wr_pfn1,
    input  logic              wr_v1,
    input  logic              wr_d1,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    output logic [1:0]        res_code,
    output logic [VA_W-1:0]   res_pa,
    output logic              res_wr_ok
);
    ptb_entry_t       wr_ent;
    ptb_entry_t       ent_q [NUM_ENT];
    logic             hit_any;
    logic             half_v;
    logic             half_d;
    logic [PFN_W-1:0] half_pfn;
    logic [VA_W-1:0]  half_offs;
    ptb_result_t      res_d;
    ptb_result_t      res_q;

    assign wr_ent = '{vpn2: wr_vpn2, asid: wr_asid, glob: wr_global,
                      mask: wr_mask, pfn0: wr_pfn0, v0: wr_v0, d0: wr_d0,
                      pfn1: wr_pfn1, v1: wr_v1, d1: wr_d1};

    ptb_store #(.NUM_ENT(NUM_ENT)) i_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_ent (wr_ent),
        .ent_q  (ent_q)
    );

    ptb_match #(.NUM_ENT(NUM_ENT)) i_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent       (ent_q),
        .lk_va     (lk_va),
        .lk_asid   (lk_asid),
        .hit_any   (hit_any),
        .half_v    (half_v),
        .half_d    (half_d),
        .half_pfn  (half_pfn),
        .half_offs (half_offs)
    );

    always_comb begin
        res_d = '{code: RES_NOMATCH, pa: '0, wr_ok: 1'b0};
        if (hit_any) begin
            if (!half_v) begin
                res_d.code = RES_INVALID;
            end else if (lk_write && !half_d) begin
                res_d.code = RES_MODIFIED;
            end else begin
                res_d.code  = RES_MATCH;
                res_d.pa    = {half_pfn, {PAGE_SHIFT{1'b0}}} | half_offs;
                res_d.wr_ok = half_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '{code: RES_NOMATCH, pa: '0, wr_ok: 1'b0};
        else        res_q <= res_d;
    end

    assign res_code  = res_q.code;
    assign res_pa    = res_q.pa;
    assign res_wr_ok = res_q.wr_ok;

    AST_FAULT_NO_XLATE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_code != RES_MATCH) |-> (res_pa == '0) && !res_wr_ok); // R8
    AST_STORE_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lk_write) && res_code == RES_MATCH) |-> res_wr_ok); // R7
    AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (res_code == RES_MATCH) |-> res_pa[PAGE_SHIFT-1:0] == $past(lk_va[PAGE_SHIFT-1:0])); // R7
    AST_LOAD_NOT_MODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(lk_write) |-> res_code != RES_MODIFIED); // R6
endmodule

// File: tb/test_ptb_top.sv
module test_ptb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [18:0] wr_vpn2 = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic [11:0] wr_mask = '0;
    logic [19:0] wr_pfn0 = '0;
    logic        wr_v0 = 1'b0;
    logic        wr_d0 = 1'b0;
    logic [19:0] wr_pfn1 = '0;
    logic        wr_v1 = 1'b0;
    logic        wr_d1 = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_write = 1'b0;
    logic [1:0]  res_code;
    logic [31:0] res_pa;
    logic        res_wr_ok;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ptb_top i_ptb_top (.*);

    typedef struct packed {
        logic [31:0] va;
        logic [7:0]  asid;
        logic        wr;
        logic [1:0]  code;
        logic [31:0] pa;
        logic        wok;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h0040_0123, 8'd5, 1'b0, 2'b00, 32'h0010_0123, 1'b1}, // R2 R7 R9 even 4K, E0 beats E3
        '{32'h0040_1ABC, 8'd5, 1'b1, 2'b11, 32'h0,         1'b0}, // R6 odd clean store
        '{32'h0040_1ABC, 8'd5, 1'b0, 2'b00, 32'h0020_0ABC, 1'b0}, // R4 R7 odd load
        '{32'h0040_0FFF, 8'd7, 1'b1, 2'b00, 32'h0050_0FFF, 1'b1}, // R2 other identifier
        '{32'h0040_0010, 8'd9, 1'b0, 2'b01, 32'h0,         1'b0}, // R8 identifier mismatch
        '{32'h1000_2345, 8'd3, 1'b0, 2'b10, 32'h0,         1'b0}, // R5 global 16K even invalid
        '{32'h1000_2345, 8'd3, 1'b1, 2'b10, 32'h0,         1'b0}, // R5 store invalid
        '{32'h1000_6345, 8'd3, 1'b1, 2'b00, 32'h4000_2345, 1'b1}, // R3 R4 16K odd
        '{32'h8012_3456, 8'd0, 1'b0, 2'b00, 32'hA012_3456, 1'b1}, // R3 16M even
        '{32'h81AB_CDEF, 8'd0, 1'b1, 2'b11, 32'h0,         1'b0}, // R6 16M odd store
        '{32'h81AB_CDEF, 8'd0, 1'b0, 2'b00, 32'hB1AB_CDEF, 1'b0}, // R4 16M odd load
        '{32'h8200_0000, 8'd0, 1'b0, 2'b01, 32'h0,         1'b0}, // R3 R8 outside 16M pair
        '{32'h0000_1000, 8'd0, 1'b0, 2'b10, 32'h0,         1'b0}  // R1 cleared entries invalid
    };

    task automatic check(string req, logic [1:0] ec, logic [31:0] ep, logic ew);
        n_checks++;
        if (res_code !== ec || res_pa !== ep || res_wr_ok !== ew) begin
            n_fail++;
            $display("FAIL %s: got code=%b pa=%h wok=%b, expected code=%b pa=%h wok=%b",
                     req, res_code, res_pa, res_wr_ok, ec, ep, ew);
        end
    endtask

    task automatic load(int idx, logic [31:0] va, logic [7:0] asid, logic g,
                        logic [11:0] m, logic [19:0] p0, logic v0, logic d0,
                        logic [19:0] p1, logic v1, logic d1);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn2 = va[31:13]; wr_asid = asid;
        wr_global = g; wr_mask = m; wr_pfn0 = p0; wr_v0 = v0; wr_d0 = d0;
        wr_pfn1 = p1; wr_v1 = v1; wr_d1 = d1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(logic [31:0] va, logic [7:0] asid, logic w);
        lk_va = va; lk_asid = asid; lk_write = w;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", 2'b01, 32'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        load(0, 32'h0040_0000, 8'd5, 1'b0, 12'h000, 20'h00100, 1, 1, 20'h00200, 1, 0);
        load(1, 32'h1000_0000, 8'd0, 1'b1, 12'h003, 20'h30000, 0, 0, 20'h40000, 1, 1);
        load(2, 32'h0040_0000, 8'd7, 1'b0, 12'h000, 20'h00500, 1, 1, 20'h00600, 1, 1);
        load(3, 32'h0040_0000, 8'd5, 1'b0, 12'h000, 20'h00900, 1, 1, 20'h00900, 1, 1);
        load(4, 32'h8000_0000, 8'd0, 1'b1, 12'hFFF, 20'hA0000, 1, 1, 20'hB1000, 1, 0);
        for (int i = 0; i < NV; i++) begin
            lookup(VECS[i].va, VECS[i].asid, VECS[i].wr);
            check($sformatf("vector %0d", i), VECS[i].code, VECS[i].pa, VECS[i].wok);
        end
        // R10: rewrite entry 0 while looking it up in the same cycle
        lk_va = 32'h0040_0123; lk_asid = 8'd5; lk_write = 1'b0;
        wr_en = 1'b1; wr_idx = 4'd0; wr_vpn2 = 19'(32'h0040_0000 >> 13); wr_asid = 8'd5;
        wr_global = 1'b0; wr_mask = 12'h000; wr_pfn0 = 20'h00700; wr_v0 = 1'b1; wr_d0 = 1'b0;
        wr_pfn1 = 20'h00200; wr_v1 = 1'b1; wr_d1 = 1'b0;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 same-cycle lookup sees old entry", 2'b00, 32'h0010_0123, 1'b1);
        @(posedge clk);
        @(negedge clk);
        check("R10 next lookup sees new entry", 2'b00, 32'h0070_0123, 1'b0);
        // R6: now-clean even half refuses a store
        lookup(32'h0040_0123, 8'd5, 1'b1);
        check("R6 store to rewritten clean half", 2'b11, 32'h0, 1'b0);
        // R1: synchronous reset clears result and entries
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 result cleared by reset", 2'b01, 32'h0, 1'b0);
        rst_n = 1'b1;
        lookup(32'h8012_3456, 8'd0, 1'b0);
        check("R1 entries cleared by reset", 2'b01, 32'h0, 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule